// File: doc/BRIEF.md
# Buffered UART with Interrupt Aggregation

This block is a full-duplex asynchronous serial port. A host writes bytes into a 16-entry transmit queue, and a serializer sends them as start / data / optional parity / stop frames on the TXD pin. The receiver oversamples RXD at sixteen ticks per bit and takes each bit at its mid-point. It queues every character with four error flags in a 16-entry receive queue, so the host always sees the status of the exact byte it pops.

The transmit and receive sides each have their own tick generator, and they run without reference to each other. Both use one programmable divisor. Four interrupt sources are each gated by a mask bit and merged into a single interrupt line: receive level, transmit level, modem-input change and receive error.

The host interface has a 3-bit address, separate write and read strobes, and 16-bit data in each direction. Register addresses: 0 data, 1 status, 2 divisor, 3 mask, 4 config, 5 interrupt status, 6 modem inputs.

Top module: `buf_uart`

## Requirements
- R1: After reset, TXD is high and IRQ is low. Status (address 1) reads 0x0005, with the bits [0] TX empty, [1] TX full, [2] RX empty, [3] RX full and [4] TX overflow. Config (address 4) reads 0x0001.
- R2: The transmit frame is one low start bit, then 8 data bits LSB first, then a parity bit if it is enabled, then one high stop bit. TXD stays high while the transmitter is idle.
- R3: Every bit lasts 16*(divisor+1) clock cycles. The divisor is at address 2.
- R4: The transmit queue holds 16 bytes. A write to address 0 while the queue is full is ignored and sets status bit 4. Writing 1 to bit 0 of address 1 clears status bit 4.
- R5: The receiver samples each bit at its mid-point. A low pulse on RXD shorter than half a bit is rejected as a false start and stores nothing.
- R6: A read of address 0 returns the oldest received entry and removes it from the queue. The entry is {overrun[11], break[10], parity error[9], framing error[8], data[7:0]}.
- R7: Config bit 10 enables parity and config bit 11 selects odd parity; with bit 11 at 0 the parity is even. A received parity bit that does not match sets entry bit 9, and the data is still stored.
- R8: A stop bit sampled low on a frame with nonzero content sets entry bit 8. The receiver then waits for RXD to go high before it looks for a new start.
- R9: If RXD stays low from the start bit through the stop-bit sample, the block stores the entry 0x400, which is the break flag with a zero byte. The receiver does not resume until the line returns high.
- R10: A character that arrives while the receive queue is full is lost. The next character that is stored carries the overrun flag in bit 11.
- R11: The RX source (interrupt bit 0) is active while the receive count is at least config[4:0]. The TX source (bit 1) is active while the transmit count is at most config[9:5].
- R12: The modem source (bit 2) latches on any change of modemIn, and modemIn reads back at address 6. The error source (bit 3) latches when an entry is stored with any flag set or a character is lost. Writing 1 to the matching bit of address 5 clears each latched source.
- R13: IRQ is high exactly when some source in address 5 is active and the same bit of the mask at address 3 is set.
- R14: Transmission and reception can run at the same time without disturbing each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rstN | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register address |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe (pops RX at address 0) |
| wrData | input | 16 | Write data |
| rdData | output | 16 | Read data for the current address |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| modemIn | input | 4 | Modem status inputs |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its default parameters: queue depth 16, a 16-bit divisor and a 16-bit host bus. At run time it programs a divisor of 1, so a bit lasts 32 cycles. It also uses a divisor of 3 once, to show that the bit time follows the divisor. At that speed the bench can fill both queues to depth 16 and push one byte past them within a few thousand cycles. This brings transmit overflow, receive overrun, the level interrupts at their thresholds, and a break longer than a frame within reach.

// File: rtl/buf_uart_pkg.sv
package buf_uart_pkg;
  localparam int BYTE_W  = 8;
  localparam int ENTRY_W = 12;
  localparam int FLG_FRM = 8;
  localparam int FLG_PAR = 9;
  localparam int FLG_BRK = 10;
  localparam int FLG_OVR = 11;
  localparam logic [2:0] A_DATA = 3'd0, A_STAT = 3'd1, A_DIV = 3'd2, A_MASK = 3'd3,
                         A_CFG = 3'd4, A_INT = 3'd5, A_MODEM = 3'd6;
  localparam int INT_RX = 0, INT_TX = 1, INT_MDM = 2, INT_ERR = 3;

  typedef struct packed {
    logic              txPush;
    logic              rxPop;
    logic [BYTE_W-1:0] txByte;
  } uartStb_t;

  typedef enum logic [2:0] {RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP, RX_WAITHI} rxState_t;
endpackage

// File: rtl/buf_uart_fifo.sv
module buf_uart_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 16,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic [W-1:0]     pushData,
  input  logic             pop,
  output logic [W-1:0]     headData,
  output logic [CNT_W-1:0] count
);
  logic [W-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic doPush, doPop, isFull;

  assign isFull   = int'(count) == DEPTH;
  assign doPush   = push && !isFull;
  assign doPop    = pop && (count != '0);
  assign headData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doPush) wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      if (doPush && !doPop)      count <= count + 1'b1;
      else if (doPop && !doPush) count <= count - 1'b1;
    end
  end

  // R4
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (push && isFull && !pop) |=> $stable(count));
endmodule

// File: rtl/buf_uart_dp.sv
module buf_uart_dp
  import buf_uart_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DIV_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  uartStb_t           stb,
  input  logic [DIV_W-1:0]   div,
  input  logic               parEn,
  input  logic               parOdd,
  input  logic               rxd,
  output logic               txd,
  output logic [CNT_W-1:0]   txCount,
  output logic [CNT_W-1:0]   rxCount,
  output logic [ENTRY_W-1:0] rxHead,
  output logic               errEvent
);
  // transmit side
  logic [BYTE_W-1:0] txHead;
  logic txBusy, txPop, txTick;
  logic [10:0] txShift;
  logic [3:0] txBits, txPhase;
  logic [DIV_W-1:0] txCnt;

  buf_uart_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) txQ (
    .clk, .rstN, .push(stb.txPush), .pushData(stb.txByte),
    .pop(txPop), .headData(txHead), .count(txCount));

  assign txTick = txCnt >= div;
  assign txPop  = !txBusy && (txCount != '0);
  assign txd    = txBusy ? txShift[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBusy <= 1'b0; txShift <= '1; txBits <= '0; txPhase <= '0; txCnt <= '0;
    end else if (txPop) begin
      txBusy  <= 1'b1;
      txShift <= {1'b1, parEn ? (^txHead ^ parOdd) : 1'b1, txHead, 1'b0};
      txBits  <= parEn ? 4'd11 : 4'd10;
      txPhase <= '0;
      txCnt   <= '0;
    end else begin
      txCnt <= txTick ? '0 : txCnt + 1'b1;
      if (txBusy && txTick) begin
        txPhase <= txPhase + 1'b1;
        if (txPhase == 4'd15) begin
          txShift <= {1'b1, txShift[10:1]};
          txBits  <= txBits - 1'b1;
          if (txBits == 4'd1) txBusy <= 1'b0;
        end
      end
    end
  end

  // receive side
  rxState_t rxState;
  logic rxM, rxS, rxTick, rxPush, rxFull, ovrPend, rxParBit;
  logic isBrk, frmErr, parErr;
  logic [3:0] rxPhase;
  logic [2:0] rxIdx;
  logic [BYTE_W-1:0] rxSh;
  logic [DIV_W-1:0] rxCnt;
  logic [ENTRY_W-1:0] rxEntry;

  buf_uart_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) rxQ (
    .clk, .rstN, .push(rxPush), .pushData(rxEntry),
    .pop(stb.rxPop), .headData(rxHead), .count(rxCount));

  assign rxTick   = rxCnt >= div;
  assign rxFull   = int'(rxCount) == DEPTH;
  assign rxPush   = rxTick && (rxState == RX_STOP) && (rxPhase == 4'd15);
  assign isBrk    = !rxS && (rxSh == '0) && !(parEn && rxParBit);
  assign frmErr   = !rxS && !isBrk;
  assign parErr   = parEn && !isBrk && (rxParBit != (^rxSh ^ parOdd));
  assign rxEntry  = {ovrPend, isBrk, parErr, frmErr, rxSh};
  assign errEvent = rxPush && (rxFull || ovrPend || isBrk || parErr || frmErr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxM <= 1'b1; rxS <= 1'b1; rxState <= RX_IDLE; rxPhase <= '0; rxIdx <= '0;
      rxSh <= '0; rxParBit <= 1'b0; ovrPend <= 1'b0; rxCnt <= '0;
    end else begin
      rxM   <= rxd;
      rxS   <= rxM;
      rxCnt <= rxTick ? '0 : rxCnt + 1'b1;
      if (rxPush) ovrPend <= rxFull;
      if (rxTick) begin
        rxPhase <= rxPhase + 1'b1;
        case (rxState)
          RX_IDLE: if (!rxS) begin rxState <= RX_START; rxPhase <= '0; end
          RX_START: if (rxPhase == 4'd7) begin
            rxPhase <= '0; rxIdx <= '0;
            rxState <= rxS ? RX_IDLE : RX_DATA;
          end
          RX_DATA: if (rxPhase == 4'd15) begin
            rxSh  <= {rxS, rxSh[BYTE_W-1:1]};
            rxIdx <= rxIdx + 1'b1;
            if (rxIdx == 3'd7) rxState <= parEn ? RX_PAR : RX_STOP;
          end
          RX_PAR: if (rxPhase == 4'd15) begin rxParBit <= rxS; rxState <= RX_STOP; end
          RX_STOP: if (rxPhase == 4'd15) rxState <= rxS ? RX_IDLE : RX_WAITHI;
          RX_WAITHI: if (rxS) rxState <= RX_IDLE;
          default: rxState <= RX_IDLE;
        endcase
      end
    end
  end

  // R2
  tx_start_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txBusy) |-> !txd);
  // R9
  brk_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxState == RX_WAITHI && !rxS) |=> rxState == RX_WAITHI);
  // R7
  no_par_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && !parEn) |-> !rxEntry[FLG_PAR]);
  // R10
  overrun_mark_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxPush && rxFull) |=> ovrPend);
endmodule

// File: rtl/buf_uart_ctrl.sv
module buf_uart_ctrl
  import buf_uart_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DIV_W   = 16,
  parameter int HOST_W  = 16,
  parameter int DEF_DIV = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         addr,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [HOST_W-1:0]  wrData,
  output logic [HOST_W-1:0]  rdData,
  input  logic [3:0]         modemIn,
  output logic               irq,
  output uartStb_t           stb,
  output logic [DIV_W-1:0]   div,
  output logic               parEn,
  output logic               parOdd,
  input  logic [CNT_W-1:0]   txCount,
  input  logic [CNT_W-1:0]   rxCount,
  input  logic [ENTRY_W-1:0] rxHead,
  input  logic               errEvent
);
  logic [3:0] mask, mM, mSync, mPrev, rawInt;
  logic [4:0] rxLevel, txLevel;
  logic txOvf, modemSticky, errSticky, txFullF, intClr;

  assign txFullF    = int'(txCount) == DEPTH;
  assign intClr     = wrEn && (addr == A_INT);
  assign stb.txPush = wrEn && (addr == A_DATA);
  assign stb.rxPop  = rdEn && (addr == A_DATA);
  assign stb.txByte = wrData[BYTE_W-1:0];

  assign rawInt[INT_RX]  = int'(rxCount) >= int'(rxLevel);
  assign rawInt[INT_TX]  = int'(txCount) <= int'(txLevel);
  assign rawInt[INT_MDM] = modemSticky;
  assign rawInt[INT_ERR] = errSticky;
  assign irq = |(rawInt & mask);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      div <= DIV_W'(DEF_DIV); mask <= '0; rxLevel <= 5'd1; txLevel <= '0;
      parEn <= 1'b0; parOdd <= 1'b0; txOvf <= 1'b0; modemSticky <= 1'b0;
      errSticky <= 1'b0; mM <= '0; mSync <= '0; mPrev <= '0;
    end else begin
      mM <= modemIn; mSync <= mM; mPrev <= mSync;
      if (wrEn) begin
        case (addr)
          A_DIV:  div  <= wrData[DIV_W-1:0];
          A_MASK: mask <= wrData[3:0];
          A_CFG:  {parOdd, parEn, txLevel, rxLevel} <= wrData[11:0];
          default: ;
        endcase
      end
      if (stb.txPush && txFullF)                       txOvf <= 1'b1;
      else if (wrEn && addr == A_STAT && wrData[0])    txOvf <= 1'b0;
      if (mSync != mPrev)                              modemSticky <= 1'b1;
      else if (intClr && wrData[INT_MDM])              modemSticky <= 1'b0;
      if (errEvent)                                    errSticky <= 1'b1;
      else if (intClr && wrData[INT_ERR])              errSticky <= 1'b0;
    end
  end

  always_comb begin
    rdData = '0;
    case (addr)
      A_DATA:  rdData = HOST_W'(rxHead);
      A_STAT:  rdData[4:0] = {txOvf, int'(rxCount) == DEPTH, rxCount == '0, txFullF, txCount == '0};
      A_DIV:   rdData = HOST_W'(div);
      A_MASK:  rdData[3:0] = mask;
      A_CFG:   rdData[11:0] = {parOdd, parEn, txLevel, rxLevel};
      A_INT:   rdData[3:0] = rawInt;
      A_MODEM: rdData[3:0] = mSync;
      default: ;
    endcase
  end

  // R4
  tx_ovf_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.txPush && txFullF) |=> txOvf);
  // R13
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mask == '0) |-> !irq);
  // R12
  modem_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (modemSticky && !(intClr && wrData[INT_MDM])) |=> modemSticky);
endmodule

// File: rtl/buf_uart.sv
module buf_uart
  import buf_uart_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int DIV_W   = 16,
  parameter int HOST_W  = 16,
  parameter int DEF_DIV = 6,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [HOST_W-1:0] wrData,
  output logic [HOST_W-1:0] rdData,
  input  logic              rxd,
  output logic              txd,
  input  logic [3:0]        modemIn,
  output logic              irq
);
  uartStb_t stb;
  logic [DIV_W-1:0] div;
  logic parEn, parOdd, errEvent;
  logic [CNT_W-1:0] txCount, rxCount;
  logic [ENTRY_W-1:0] rxHead;

  buf_uart_ctrl #(.DEPTH(DEPTH), .DIV_W(DIV_W), .HOST_W(HOST_W), .DEF_DIV(DEF_DIV)) ctrl (
    .clk, .rstN, .addr, .wrEn, .rdEn, .wrData, .rdData, .modemIn, .irq,
    .stb, .div, .parEn, .parOdd, .txCount, .rxCount, .rxHead, .errEvent);

  buf_uart_dp #(.DEPTH(DEPTH), .DIV_W(DIV_W)) dp (
    .clk, .rstN, .stb, .div, .parEn, .parOdd, .rxd, .txd,
    .txCount, .rxCount, .rxHead, .errEvent);
endmodule

// File: tb/tb_buf_uart.sv
module tb_buf_uart;
  localparam int BIT = 32;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, rdEn = 1'b0, rxLine = 1'b1, txd, irq;
  logic [2:0] addr = '0;
  logic [15:0] wrData = '0, rdData;
  logic [3:0] modemIn = '0;
  int tests = 0, fails = 0;

  always #10 clk = ~clk;

  buf_uart dut (.clk, .rstN, .addr, .wrEn, .rdEn, .wrData, .rdData,
                .rxd(rxLine), .txd, .modemIn, .irq);

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); addr = a; #1; d = rdData; rdEn = 1'b1;
    @(negedge clk); rdEn = 1'b0;
  endtask

  task automatic sendRx(input logic [7:0] d, input bit withPar, input logic pb, input logic stopB);
    @(negedge clk); rxLine = 1'b0; repeat (BIT) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rxLine = d[i]; repeat (BIT) @(negedge clk); end
    if (withPar) begin rxLine = pb; repeat (BIT) @(negedge clk); end
    rxLine = stopB; repeat (BIT) @(negedge clk);
    rxLine = 1'b1; repeat (BIT) @(negedge clk);
  endtask

  task automatic captureTx(input int nBits, output logic [10:0] bits, output bit got);
    int w;
    w = 0; got = 0; bits = '0;
    while (txd !== 1'b0 && w < 1000) begin @(negedge clk); w++; end
    if (txd === 1'b0) begin
      got = 1;
      repeat (BIT / 2) @(negedge clk);
      for (int i = 0; i < nBits; i++) begin repeat (BIT) @(negedge clk); bits[i] = txd; end
    end
  endtask

  task automatic t_reset();
    logic [15:0] v;
    check("R1 txd idle", {15'd0, txd}, 16'd1);
    check("R1 irq low", {15'd0, irq}, 16'd0);
    rd(3'd1, v); check("R1 status", v, 16'h0005);
    rd(3'd4, v); check("R1 config", v, 16'h0001);
  endtask

  task automatic t_txFrame();
    logic [10:0] b; bit got;
    wr(3'd0, 16'h00A5);
    captureTx(9, b, got);
    check("R2 frame seen", {15'd0, got}, 16'd1);
    check("R2 data+stop", {7'd0, b[8:0]}, {7'd0, 1'b1, 8'hA5});
    wr(3'd4, 16'h0401);                         // even parity on
    wr(3'd0, 16'h0007);
    captureTx(10, b, got);
    check("R2 R7 parity frame", {6'd0, b[9:0]}, {6'd0, 2'b11, 8'h07});
    wr(3'd4, 16'h0001);
  endtask

  task automatic t_bitTime();
    logic [10:0] b; int n; bit got;
    wr(3'd2, 16'd3);
    wr(3'd0, 16'h0001);
    n = 0;
    while (txd !== 1'b0 && n < 1000) begin @(negedge clk); n++; end
    n = 0;
    while (txd === 1'b0) begin @(negedge clk); n++; end
    check("R3 start bit cycles", 16'(n), 16'd64);
    repeat (700) @(negedge clk);
    wr(3'd2, 16'd1);
    wr(3'd0, 16'h0080);
    captureTx(9, b, got);
    check("R3 restored rate", {7'd0, b[8:0]}, {7'd0, 1'b1, 8'h80});
  endtask

  task automatic t_txOverflow();
    logic [10:0] b; logic [15:0] v; int frames; logic [7:0] last; bit got;
    for (int i = 0; i < 20; i++) wr(3'd0, 16'(8'h10 + i));
    rd(3'd1, v); check("R4 full and overflow flagged", v & 16'h0012, 16'h0012);
    frames = 0; last = '0; got = 1;
    while (got) begin
      captureTx(9, b, got);
      if (got) begin frames++; last = b[7:0]; end
    end
    check("R4 frames sent", 16'(frames), 16'd17);
    check("R4 last byte", {8'd0, last}, 16'h0020);
    wr(3'd1, 16'h0001);
    rd(3'd1, v); check("R4 overflow cleared", v & 16'h0010, 16'h0000);
  endtask

  task automatic t_rxBasic();
    logic [15:0] v;
    sendRx(8'h3C, 0, 1'b0, 1'b1);
    rd(3'd0, v); check("R6 R5 rx entry", v, 16'h003C);
    @(negedge clk); rxLine = 1'b0; repeat (4) @(negedge clk); rxLine = 1'b1;
    repeat (BIT * 12) @(negedge clk);
    rd(3'd1, v); check("R5 glitch rejected", v & 16'h0004, 16'h0004);
  endtask

  task automatic t_rxErrors();
    logic [15:0] v;
    wr(3'd4, 16'h0401);
    sendRx(8'h07, 1, 1'b1, 1'b1); rd(3'd0, v); check("R7 even good", v, 16'h0007);
    sendRx(8'h07, 1, 1'b0, 1'b1); rd(3'd0, v); check("R7 even bad", v, 16'h0207);
    wr(3'd4, 16'h0C01);
    sendRx(8'h07, 1, 1'b0, 1'b1); rd(3'd0, v); check("R7 odd good", v, 16'h0007);
    wr(3'd4, 16'h0001);
    sendRx(8'h55, 0, 1'b0, 1'b0);
    rd(3'd0, v); check("R8 framing", v, 16'h0155);
    rd(3'd1, v); check("R8 single entry", v & 16'h0004, 16'h0004);
    @(negedge clk); rxLine = 1'b0; repeat (BIT * 12) @(negedge clk);
    rxLine = 1'b1; repeat (BIT * 2) @(negedge clk);
    rd(3'd0, v); check("R9 break entry", v, 16'h0400);
    rd(3'd1, v); check("R9 single entry", v & 16'h0004, 16'h0004);
  endtask

  task automatic t_overrun();
    logic [15:0] v; int bad;
    for (int i = 0; i < 17; i++) sendRx(8'(8'h40 + i), 0, 1'b0, 1'b1);
    rd(3'd1, v); check("R10 rx full", v & 16'h0008, 16'h0008);
    bad = 0;
    for (int i = 0; i < 16; i++) begin
      rd(3'd0, v);
      if (v !== 16'(8'h40 + i)) bad++;
    end
    check("R10 kept entries", 16'(bad), 16'd0);
    sendRx(8'h99, 0, 1'b0, 1'b1);
    rd(3'd0, v); check("R10 overrun flag", v, 16'h0899);
  endtask

  task automatic t_levels();
    logic [15:0] v;
    wr(3'd4, 16'h0002); wr(3'd3, 16'h0001);
    sendRx(8'h11, 0, 1'b0, 1'b1);
    check("R11 rx below level", {15'd0, irq}, 16'd0);
    sendRx(8'h22, 0, 1'b0, 1'b1);
    check("R11 rx at level", {15'd0, irq}, 16'd1);
    rd(3'd0, v); @(negedge clk);
    check("R11 rx after pop", {15'd0, irq}, 16'd0);
    rd(3'd0, v);
    wr(3'd4, 16'h0001); wr(3'd3, 16'h0002);
    check("R11 tx empty active", {15'd0, irq}, 16'd1);
    wr(3'd0, 16'h0001); wr(3'd0, 16'h0002); wr(3'd0, 16'h0003);
    check("R11 tx above level", {15'd0, irq}, 16'd0);
    repeat (1000) @(negedge clk);
    check("R11 tx drained", {15'd0, irq}, 16'd1);
    repeat (1000) @(negedge clk);
  endtask

  task automatic t_sources();
    logic [15:0] v;
    wr(3'd3, 16'h0004);
    @(negedge clk); modemIn = 4'b0101; repeat (5) @(negedge clk);
    check("R12 modem irq", {15'd0, irq}, 16'd1);
    rd(3'd6, v); check("R12 modem value", v, 16'h0005);
    wr(3'd5, 16'h0004); @(negedge clk);
    check("R12 modem cleared", {15'd0, irq}, 16'd0);
    wr(3'd3, 16'h0000);
    rd(3'd5, v); check("R12 error latched", v & 16'h0008, 16'h0008);
    check("R13 all masked", {15'd0, irq}, 16'd0);
    wr(3'd3, 16'h0008); @(negedge clk);
    check("R13 error unmasked", {15'd0, irq}, 16'd1);
    wr(3'd5, 16'h0008); @(negedge clk);
    check("R13 error cleared", {15'd0, irq}, 16'd0);
  endtask

  task automatic t_duplex();
    logic [10:0] b; logic [15:0] v; bit got;
    fork
      sendRx(8'h5A, 0, 1'b0, 1'b1);
      begin wr(3'd0, 16'h00C3); captureTx(9, b, got); end
    join
    rd(3'd0, v); check("R14 rx during tx", v, 16'h005A);
    check("R14 tx during rx", {7'd0, b[8:0]}, {7'd0, 1'b1, 8'hC3});
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    wr(3'd2, 16'd1);
    t_txFrame();
    t_bitTime();
    t_txOverflow();
    t_rxBasic();
    t_rxErrors();
    t_overrun();
    t_levels();
    t_sources();
    t_duplex();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule